// File: doc/BRIEF.md
# Processor Checkstop Controller

This block decides when a processor core stops for good because of a hardware fault. It takes parity-error strobes from the L1 instruction cache, the L1 data cache and the L2 tag array, a strobe that reports a snoop hit on a locked L2 line, and an external stop-request pin. Each internal source passes only when its own enable bit is set in one of two configuration registers. The external pin needs no enable and always forces the stop.

Once the stop state is entered it stays until the next hard reset. While stopped, the block drives the stop output pin and the core-halt signal, and it clears every requested bus-driver output enable so that the halted core leaves the shared bus. Hard reset clears the stop state and every enable bit. Its release is synchronised to the clock, so the block sees any error or write only after the release has passed through the synchroniser.

Top module: `ckstop_ctrl`

## Requirements
- R1: A high on `ext_stop_i` at a clock edge where the internal reset is released sets the stop state at that edge, even when every enable bit is 0.
- R2: While `rst_n` is low, and for the first SYNC_STAGES clock edges after it rises, `stop_out_o` and `core_halt_o` are 0. Enable bits read back as 0. Pulling `rst_n` low clears a stop that was set earlier.
- R3: If `ext_stop_i` is held high through the reset release, `stop_out_o` rises at clock edge SYNC_STAGES+1 after `rst_n` rises (edge 3 with the defaults).
- R4: Register A (`cfg_sel_i`=0), big-endian bit 29 (vector index 2), enables stopping on an `par_icache_i` strobe.
- R5: Register A, big-endian bit 30 (vector index 1), enables stopping on a `par_dcache_i` strobe.
- R6: Register A, big-endian bit 31 (vector index 0), enables stopping on a `par_l2tag_i` strobe.
- R7: Register B (`cfg_sel_i`=1), big-endian bit 22 (vector index 9), resets to 0. When it is 1, a `snoop_lock_hit_i` strobe sets the stop. When it is 0, that strobe has no effect.
- R8: When not stopped, `bus_oe_o` equals `bus_oe_req_i`. When stopped, `bus_oe_o` is all zeros while `stop_out_o` stays 1.
- R9: The stop state is sticky. It holds with every source idle until `rst_n` goes low.
- R10: `core_halt_o` equals `stop_out_o` in every cycle.
- R11: `cfg_rdata_o` shows the enable bits of the register chosen by `cfg_sel_i`, at the positions given in R4 to R7. Every other bit reads 0. A write takes effect at the clock edge where `cfg_we_i` is high.
- R12: Writes made while `rst_n` is low, or during the first SYNC_STAGES edges after it rises, leave all enable bits at 0.
- R13: A strobe whose enable bit is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous assert |
| ext_stop_i | input | 1 | External stop-request pin, active high |
| par_icache_i | input | 1 | L1 instruction cache/tag parity-error strobe |
| par_dcache_i | input | 1 | L1 data cache/tag parity-error strobe |
| par_l2tag_i | input | 1 | L2 tag parity-error strobe |
| snoop_lock_hit_i | input | 1 | Strobe for a snoop hit on a locked L2 line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Register select: 0 = register A, 1 = register B |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_rdata_o | output | CFG_W | Read-back of the selected register |
| bus_oe_req_i | input | N_OE | Bus-driver output enables requested by the core |
| bus_oe_o | output | N_OE | Output enables after the stop mask |
| stop_out_o | output | 1 | Stop output pin, active high |
| core_halt_o | output | 1 | Halt request to the core |

## Verification
The bench uses the default parameters: a 32-bit configuration word, eight bus-driver enables and a two-stage reset synchroniser. The 32-bit word puts the big-endian bit numbers at their real positions (29, 30, 31 and 22). The two-stage synchroniser makes the blind window after reset release short enough to hit exactly, both with writes held across it and with the external pin held through it. Eight enables are enough for alternating and all-ones request patterns to show whether the mask is applied to every driver or only some.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

  // Error sources seen by the controller
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_IC  = 0;
  localparam int unsigned SRC_DC  = 1;
  localparam int unsigned SRC_L2  = 2;
  localparam int unsigned SRC_SNP = 3;

  // Register select codes
  localparam logic REG_A = 1'b0;
  localparam logic REG_B = 1'b1;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Register that holds the enable for a source
  function automatic logic src_reg(int unsigned id);
    return (id == SRC_SNP) ? REG_B : REG_A;
  endfunction

  // Enable position in big-endian numbering (bit 0 = MSB)
  function automatic int unsigned src_be_pos(int unsigned id);
    case (id)
      SRC_IC:  return 29;
      SRC_DC:  return 30;
      SRC_L2:  return 31;
      default: return 22;
    endcase
  endfunction

  // Same position as a little-endian vector index
  function automatic int unsigned src_bit(int unsigned w, int unsigned id);
    return w - 1 - src_be_pos(id);
  endfunction

endpackage

// File: rtl/ckstop_rst_sync.sv
module ckstop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ckstop_cfg_regs.sv
module ckstop_cfg_regs
  import ckstop_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             reg_sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  output src_vec_t         en_o,
  output logic [CFG_W-1:0] rdata_o
);

  src_vec_t en_q;
  src_vec_t en_d;
  src_vec_t wr_hit;
  logic     unused_wdata;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int unsigned BIT = src_bit(CFG_W, g);
    localparam logic        SEL = src_reg(g);
    assign wr_hit[g] = wr_en_i && (reg_sel_i == SEL);
    assign en_d[g]   = wr_hit[g] ? wdata_i[BIT] : en_q[g];
  end

  // Only the enable positions are stored
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (|wr_hit) en_q <= en_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int unsigned g = 0; g < NUM_SRC; g++) begin
      if (reg_sel_i == src_reg(g)) rdata_o[src_bit(CFG_W, g)] = en_q[g];
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/ckstop_src_gate.sv
module ckstop_src_gate
  import ckstop_pkg::*;
(
  input  src_vec_t strobe_i,
  input  src_vec_t en_i,
  output logic     hit_o
);

  src_vec_t gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    assign gated[g] = strobe_i[g] & en_i[g];
  end

  assign hit_o = |gated;

endmodule

// File: rtl/ckstop_core.sv
module ckstop_core #(
  parameter int unsigned N_OE = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            ext_i,
  input  logic [N_OE-1:0] oe_req_i,
  output logic            stop_o,
  output logic            halt_o,
  output logic [N_OE-1:0] oe_o
);

  logic stop_q;
  logic stop_d;
  logic stop_ce;

  // Once set, the flag never needs another clock enable
  assign stop_ce = ~stop_q;

  always_comb begin
    stop_d = hit_i | ext_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stop_q <= 1'b0;
    else if (stop_ce) stop_q <= stop_d;
  end

  for (genvar i = 0; i < N_OE; i++) begin : g_oe
    assign oe_o[i] = oe_req_i[i] & ~stop_q;
  end

  assign stop_o = stop_q;
  assign halt_o = stop_q;

endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl
  import ckstop_pkg::*;
#(
  parameter int unsigned CFG_W       = 32,
  parameter int unsigned N_OE        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_stop_i,
  input  logic             par_icache_i,
  input  logic             par_dcache_i,
  input  logic             par_l2tag_i,
  input  logic             snoop_lock_hit_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic [N_OE-1:0]  bus_oe_req_i,
  output logic [N_OE-1:0]  bus_oe_o,
  output logic             stop_out_o,
  output logic             core_halt_o
);

  logic     rst_int_n;
  src_vec_t src_strobe;
  src_vec_t src_en;
  logic     any_hit;

  assign src_strobe[SRC_IC]  = par_icache_i;
  assign src_strobe[SRC_DC]  = par_dcache_i;
  assign src_strobe[SRC_L2]  = par_l2tag_i;
  assign src_strobe[SRC_SNP] = snoop_lock_hit_i;

  ckstop_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  ckstop_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
    .clk_i     (clk),
    .rst_ni    (rst_int_n),
    .wr_en_i   (cfg_we_i),
    .reg_sel_i (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .en_o      (src_en),
    .rdata_o   (cfg_rdata_o)
  );

  ckstop_src_gate u_gate (
    .strobe_i (src_strobe),
    .en_i     (src_en),
    .hit_o    (any_hit)
  );

  ckstop_core #(.N_OE(N_OE)) u_core (
    .clk_i    (clk),
    .rst_ni   (rst_int_n),
    .hit_i    (any_hit),
    .ext_i    (ext_stop_i),
    .oe_req_i (bus_oe_req_i),
    .stop_o   (stop_out_o),
    .halt_o   (core_halt_o),
    .oe_o     (bus_oe_o)
  );

endmodule

// File: rtl/ckstop_ctrl_chk.sv
module ckstop_ctrl_chk
  import ckstop_pkg::*;
#(
  parameter int unsigned N_OE = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_int_n,
  input logic            ext_stop_i,
  input logic            par_icache_i,
  input logic            par_dcache_i,
  input logic            par_l2tag_i,
  input logic            snoop_lock_hit_i,
  input src_vec_t        src_en,
  input logic [N_OE-1:0] bus_oe_o,
  input logic            stop_out_o,
  input logic            core_halt_o
);

  // R1
  ext_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && ext_stop_i) |=> stop_out_o);

  // R2
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (!stop_out_o && src_en == '0));

  // R4
  icache_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && par_icache_i && src_en[SRC_IC]) |=> stop_out_o);

  // R5
  dcache_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && par_dcache_i && src_en[SRC_DC]) |=> stop_out_o);

  // R6
  l2tag_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && par_l2tag_i && src_en[SRC_L2]) |=> stop_out_o);

  // R7
  snoop_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int_n && snoop_lock_hit_i && src_en[SRC_SNP]) |=> stop_out_o);

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_out_o |-> (bus_oe_o == '0));

  // R9
  sticky_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_out_o |=> stop_out_o);

  // R10
  halt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt_o == stop_out_o);

  // R13
  quiet_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_out_o && !ext_stop_i
     && !(par_icache_i && src_en[SRC_IC]) && !(par_dcache_i && src_en[SRC_DC])
     && !(par_l2tag_i && src_en[SRC_L2]) && !(snoop_lock_hit_i && src_en[SRC_SNP]))
    |=> !stop_out_o);

endmodule

bind ckstop_ctrl ckstop_ctrl_chk #(.N_OE(N_OE)) u_ckstop_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rst_int_n        (rst_int_n),
  .ext_stop_i       (ext_stop_i),
  .par_icache_i     (par_icache_i),
  .par_dcache_i     (par_dcache_i),
  .par_l2tag_i      (par_l2tag_i),
  .snoop_lock_hit_i (snoop_lock_hit_i),
  .src_en           (src_en),
  .bus_oe_o         (bus_oe_o),
  .stop_out_o       (stop_out_o),
  .core_halt_o      (core_halt_o)
);

// File: tb/test_ckstop_ctrl.sv
`timescale 1ns/1ps
module test_ckstop_ctrl;

  localparam int CFG_W = 32;
  localparam int N_OE  = 8;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ext_stop_i, par_icache_i, par_dcache_i, par_l2tag_i, snoop_lock_hit_i;
  logic             cfg_we_i, cfg_sel_i;
  logic [CFG_W-1:0] cfg_wdata_i;
  logic [CFG_W-1:0] cfg_rdata_o;
  logic [N_OE-1:0]  bus_oe_req_i, bus_oe_o;
  logic             stop_out_o, core_halt_o;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string phase = "R2";

  always #2 clk = ~clk;

  ckstop_ctrl #(.CFG_W(CFG_W), .N_OE(N_OE), .SYNC_STAGES(SYNC)) i_ckstop_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_stop_i(ext_stop_i),
    .par_icache_i(par_icache_i), .par_dcache_i(par_dcache_i),
    .par_l2tag_i(par_l2tag_i), .snoop_lock_hit_i(snoop_lock_hit_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .bus_oe_req_i(bus_oe_req_i), .bus_oe_o(bus_oe_o),
    .stop_out_o(stop_out_o), .core_halt_o(core_halt_o)
  );

  // Reference model: enables kept as {snoop, l2, dcache, icache}
  int       m_rel;
  bit       m_stop;
  bit [3:0] m_en;
  bit [3:0] m_src;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel  = 0;
      m_stop = 0;
      m_en   = 0;
    end else begin
      if (m_rel >= SYNC) begin
        m_src = {snoop_lock_hit_i, par_l2tag_i, par_dcache_i, par_icache_i};
        if (ext_stop_i || (m_src & m_en) != 0) m_stop = 1;
        if (cfg_we_i) begin
          if (!cfg_sel_i) begin
            m_en[0] = cfg_wdata_i[2];
            m_en[1] = cfg_wdata_i[1];
            m_en[2] = cfg_wdata_i[0];
          end else begin
            m_en[3] = cfg_wdata_i[9];
          end
        end
      end
      if (m_rel < SYNC) m_rel++;
    end
  end

  function automatic logic [CFG_W-1:0] exp_rdata();
    logic [CFG_W-1:0] r = '0;
    if (!cfg_sel_i) begin
      r[2] = m_en[0];
      r[1] = m_en[1];
      r[0] = m_en[2];
    end else begin
      r[9] = m_en[3];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare against the model every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk({phase, " stop_out"}, 64'(stop_out_o), 64'(m_stop));
      chk("R10 core_halt", 64'(core_halt_o), 64'(m_stop));
      chk("R8 bus_oe", 64'(bus_oe_o), 64'(m_stop ? '0 : bus_oe_req_i));
      chk("R11 rdata", 64'(cfg_rdata_o), 64'(exp_rdata()));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [CFG_W-1:0] d);
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  // which: 0 icache, 1 dcache, 2 l2 tag, 3 snoop, 4 external pin
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: par_icache_i = 1;
      1: par_dcache_i = 1;
      2: par_l2tag_i = 1;
      3: snoop_lock_hit_i = 1;
      default: ext_stop_i = 1;
    endcase
    @(negedge clk);
    par_icache_i = 0; par_dcache_i = 0; par_l2tag_i = 0;
    snoop_lock_hit_i = 0; ext_stop_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(SYNC);
  endtask

  initial begin
    rst_n = 0; ext_stop_i = 0; par_icache_i = 0; par_dcache_i = 0;
    par_l2tag_i = 0; snoop_lock_hit_i = 0; cfg_we_i = 0; cfg_sel_i = 0;
    cfg_wdata_i = '0; bus_oe_req_i = 8'h5A;

    // R2 / R12: writes and strobes during reset and the release window
    phase = "R12";
    cyc(1);
    cfg_we_i = 1; cfg_wdata_i = '1;
    par_icache_i = 1; par_dcache_i = 1;
    cyc(1); cfg_sel_i = 1;
    cyc(1); cfg_sel_i = 0;
    rst_n = 1;
    cyc(1); cfg_sel_i = 1;
    cyc(1);
    cfg_we_i = 0; par_icache_i = 0; par_dcache_i = 0;
    cfg_sel_i = 0; cyc(1);
    chk("R12 reg A after release", 64'(cfg_rdata_o), 64'h0);
    cfg_sel_i = 1; cyc(1);
    chk("R12 reg B after release", 64'(cfg_rdata_o), 64'h0);
    chk("R2 stop after release", 64'(stop_out_o), 64'h0);

    // R13: strobes with every enable off
    phase = "R13";
    for (int k = 0; k < 4; k++) pulse(k);
    bus_oe_req_i = 8'hA5; cyc(2);
    chk("R13 no stop from disabled strobes", 64'(stop_out_o), 64'h0);

    // R11: only enable positions are kept
    phase = "R11";
    wr(0, 32'hFFFF_FFF8);
    wr(1, ~(32'h1 << 9));
    cfg_sel_i = 0; cyc(1);
    chk("R11 reg A non-enable bits", 64'(cfg_rdata_o), 64'h0);
    wr(0, 32'h7);
    cfg_sel_i = 0; cyc(1);
    chk("R11 reg A all enables", 64'(cfg_rdata_o), 64'h7);
    wr(0, 32'h0);

    // R4: icache enable only
    phase = "R4";
    wr(0, 32'h1 << 2);
    pulse(1); pulse(2); pulse(3);
    chk("R4 other strobes ignored", 64'(stop_out_o), 64'h0);
    pulse(0);
    chk("R4 icache parity stops", 64'(stop_out_o), 64'h1);

    // R9 / R8: sticky, bus drivers off
    phase = "R9";
    bus_oe_req_i = 8'hFF; cyc(6);
    chk("R9 stays stopped", 64'(stop_out_o), 64'h1);
    chk("R8 all drivers off", 64'(bus_oe_o), 64'h0);

    // R2: reset clears the stop
    phase = "R2";
    do_reset();
    chk("R2 stop cleared", 64'(stop_out_o), 64'h0);
    chk("R8 drivers pass", 64'(bus_oe_o), 64'hFF);

    phase = "R5";
    wr(0, 32'h1 << 1);
    pulse(0);
    pulse(1);
    chk("R5 dcache parity stops", 64'(stop_out_o), 64'h1);
    do_reset();

    phase = "R6";
    wr(0, 32'h1);
    pulse(2);
    chk("R6 l2 tag parity stops", 64'(stop_out_o), 64'h1);
    do_reset();

    phase = "R7";
    pulse(3); cyc(1);
    chk("R7 snoop disabled", 64'(stop_out_o), 64'h0);
    wr(1, 32'h1 << 9);
    cfg_sel_i = 1; cyc(1);
    chk("R7 reg B enable reads back", 64'(cfg_rdata_o), 64'h200);
    pulse(3);
    chk("R7 snoop hit stops", 64'(stop_out_o), 64'h1);
    do_reset();

    phase = "R1";
    bus_oe_req_i = 8'h3C;
    pulse(4);
    chk("R1 external pin stops with enables off", 64'(stop_out_o), 64'h1);

    // R3: pin held through the reset release
    phase = "R3";
    @(negedge clk);
    rst_n = 0; ext_stop_i = 1;
    cyc(2);
    rst_n = 1;
    repeat (SYNC) @(posedge clk);
    #1 chk("R3 not stopped inside sync window", 64'(stop_out_o), 64'h0);
    @(posedge clk);
    #1 chk("R3 stop after window", 64'(stop_out_o), 64'h1);
    cyc(2);
    ext_stop_i = 0;
    cyc(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule